// File: doc/BRIEF.md
# Chain Stream Word Deserializer

This block receives data from a row of serial converters wired in a chain. Each converter passes its neighbour's data along, so the host sees one serial data line and one frame-sync line, both clocked by the serial clock. The block samples the two lines on every rising clock edge. A high-to-low change of frame sync marks the start of a frame. From that point the stream is cut into back-to-back 32-bit words, most significant bit first. The first word comes from the converter nearest the host, and each later word comes from the next converter along the chain.

Each completed word is presented for one clock together with its position in the chain, which is 0 for the nearest converter. The host sets how many converters are in the chain. That number may not exceed the converters' decimation rate divided by 32, so the `DEC_RATE` parameter sets the upper bound. The block checks frame sync against the expected pattern: low for the whole first word, high for all later words. When the pattern is broken, it raises an error strobe.

Top module: `chain_word_rx`

## Requirements
- R1: After a synchronous reset, `word_valid` and `frame_err` are 0, and `word_data` and `word_dev` are all zeros. Frame sync must be seen high on at least one sampled edge before a low sample can open a frame. A line held low from reset therefore produces no word.
- R2: A frame opens at the rising edge where `fsync_in` is sampled low after being sampled high on the previous edge. The data bit sampled at that edge is bit 31 of word 0. The next 31 sampled bits fill bits 30 down to 0 in that order.
- R3: `word_valid` is high for exactly one clock, starting just after the edge that samples a word's last bit. `word_data` and `word_dev` change only when `word_valid` rises, and they keep their values between words.
- R4: The words of a frame follow each other with no gap, one every 32 clocks. They carry the indices 0, 1, 2, … in arrival order.
- R5: `dev_count` is captured when a frame opens. A value of 0 counts as 1, and a value above `DEC_RATE/32` (8 by default) counts as that maximum. Once that many words have been delivered, all further bits are ignored until the next falling edge of frame sync.
- R6: During word 0, `fsync_in` sampled high at any of bits 30 down to 0 gives a one-clock `frame_err` strobe. The frame is then abandoned, and that word is never delivered.
- R7: During any later word, `fsync_in` sampled low gives a one-clock `frame_err` strobe. If that sample is a falling edge, a new frame opens with that bit as bit 31 of word 0. Otherwise the frame is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; both lines are sampled on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdo_in | input | 1 | Serial data stream from the nearest converter in the chain |
| fsync_in | input | 1 | Frame sync from the nearest converter; low during word 0 |
| dev_count | input | 4 | Number of converters in the chain (clamped to 1..8) |
| word_data | output | 32 | Last completed word |
| word_dev | output | 3 | Chain position of the converter that produced `word_data` |
| word_valid | output | 1 | One-clock strobe marking a new word |
| frame_err | output | 1 | One-clock strobe marking a frame-sync violation |

## Verification
Properties checked on every cycle:
- The outputs are quiet after reset.
- No two words are closer than 32 clocks apart.
- Chain indices step up by one within a frame.
- Frame sync was low on the last bit of every word 0 and high on the last bit of every later word.
- A word and an error are never reported together.

Some behaviour can only be shown by the bench scenarios. These are:
- Bit order and the exact content of each word.
- Clamping of the device count.
- Silence after the configured number of words.
- Resynchronisation when frame sync falls in the middle of a frame.
- Abandonment when frame sync goes high early.
- Holding of the data between words.

// File: rtl/cwr_pkg.sv
package cwr_pkg;

  // Receiver phase: waiting for a frame-sync fall, or cutting words.
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rx_state_e;

  // Bits needed to hold values 0..n-1 (at least one bit).
  function automatic int unsigned width_of(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/cwr_fs_edge.sv
// Keeps the previous frame-sync sample and flags a high-to-low change.
module cwr_fs_edge (
  input  logic clk,
  input  logic rst,
  input  logic fsync_in,
  output logic fs_fall
);

  logic fs_q;

  // Reset to low, so a line that stays low after reset never looks like a fall.
  always_ff @(posedge clk) begin
    if (rst) fs_q <= 1'b0;
    else     fs_q <= fsync_in;
  end

  assign fs_fall = fs_q & ~fsync_in;

endmodule

// File: rtl/cwr_shift.sv
// MSB-first input shift register; word_next is the word including the bit at the current edge.
module cwr_shift #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word_next
);

  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst)           sh_q <= '0;
    else if (shift_en) sh_q <= {sh_q[WORD_W-2:0], bit_in};
  end

  assign word_next = {sh_q[WORD_W-2:0], bit_in};

endmodule

// File: rtl/cwr_frame_ctl.sv
// Frame state: counts bits within a word, tracks the chain index and checks frame sync.
module cwr_frame_ctl
  import cwr_pkg::*;
#(
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned MAX_DEV = 8,
  parameter int unsigned IDX_W   = 3,
  parameter int unsigned CNT_W   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync_in,
  input  logic             fs_fall,
  input  logic [CNT_W-1:0] dev_count,
  output logic             shift_en,
  output logic             word_done,
  output logic             err_evt,
  output logic [IDX_W-1:0] cur_dev
);

  localparam int unsigned     BC_W     = width_of(WORD_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(WORD_W - 1);

  rx_state_e        st_q, st_d;
  logic [BC_W-1:0]  bit_q, bit_d;
  logic [IDX_W-1:0] dev_q, dev_d;
  logic [IDX_W-1:0] lim_q, lim_d;

  // Index of the last converter for the requested count, clamped to 1..MAX_DEV.
  function automatic logic [IDX_W-1:0] last_index(input logic [CNT_W-1:0] n);
    if (n == '0)               return '0;
    if (n > CNT_W'(MAX_DEV))   return IDX_W'(MAX_DEV - 1);
    return IDX_W'(n - 1'b1);
  endfunction

  always_comb begin
    st_d      = st_q;
    bit_d     = bit_q;
    dev_d     = dev_q;
    lim_d     = lim_q;
    word_done = 1'b0;
    err_evt   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (fs_fall) begin
          st_d  = ST_RUN;
          bit_d = BC_W'(1);
          dev_d = '0;
          lim_d = last_index(dev_count);
        end
      end
      ST_RUN: begin
        if (dev_q == '0 && fsync_in) begin
          // Sync released before word 0 finished.
          err_evt = 1'b1;
          st_d    = ST_IDLE;
        end else if (dev_q != '0 && !fsync_in) begin
          // Sync low during a later word: restart on a true fall, else give up.
          err_evt = 1'b1;
          if (fs_fall) begin
            bit_d = BC_W'(1);
            dev_d = '0;
            lim_d = last_index(dev_count);
          end else begin
            st_d = ST_IDLE;
          end
        end else if (bit_q == LAST_BIT) begin
          word_done = 1'b1;
          bit_d     = '0;
          if (dev_q == lim_q) st_d  = ST_IDLE;
          else                dev_d = dev_q + 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      bit_q <= '0;
      dev_q <= '0;
      lim_q <= '0;
    end else begin
      st_q  <= st_d;
      bit_q <= bit_d;
      dev_q <= dev_d;
      lim_q <= lim_d;
    end
  end

  assign shift_en = fs_fall || (st_q == ST_RUN);
  assign cur_dev  = dev_q;

endmodule

// File: rtl/chain_word_rx.sv
// Host-side receiver for a chain of serial converters sharing one data line.
module chain_word_rx #(
  parameter  int unsigned WORD_W   = 32,
  parameter  int unsigned DEC_RATE = 256,
  localparam int unsigned MAX_DEV  = DEC_RATE / WORD_W,
  localparam int unsigned IDX_W    = cwr_pkg::width_of(MAX_DEV),
  localparam int unsigned CNT_W    = cwr_pkg::width_of(MAX_DEV + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdo_in,
  input  logic              fsync_in,
  input  logic [CNT_W-1:0]  dev_count,
  output logic [WORD_W-1:0] word_data,
  output logic [IDX_W-1:0]  word_dev,
  output logic              word_valid,
  output logic              frame_err
);

  logic              fs_fall;
  logic              shift_en;
  logic              word_done;
  logic              err_evt;
  logic [IDX_W-1:0]  cur_dev;
  logic [WORD_W-1:0] word_next;

  cwr_fs_edge u_edge (
    .clk      (clk),
    .rst      (rst),
    .fsync_in (fsync_in),
    .fs_fall  (fs_fall)
  );

  cwr_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shift_en),
    .bit_in    (sdo_in),
    .word_next (word_next)
  );

  cwr_frame_ctl #(
    .WORD_W  (WORD_W),
    .MAX_DEV (MAX_DEV),
    .IDX_W   (IDX_W),
    .CNT_W   (CNT_W)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .fsync_in  (fsync_in),
    .fs_fall   (fs_fall),
    .dev_count (dev_count),
    .shift_en  (shift_en),
    .word_done (word_done),
    .err_evt   (err_evt),
    .cur_dev   (cur_dev)
  );

  // Registered outputs: data and index load only when a word completes.
  always_ff @(posedge clk) begin
    if (rst) begin
      word_valid <= 1'b0;
      frame_err  <= 1'b0;
      word_data  <= '0;
      word_dev   <= '0;
    end else begin
      word_valid <= word_done;
      frame_err  <= err_evt;
      if (word_done) begin
        word_data <= word_next;
        word_dev  <= cur_dev;
      end
    end
  end

endmodule

// File: rtl/cwr_checker.sv
// Cycle-level properties of the chain receiver, attached by bind.
module cwr_checker #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             fsync_in,
  input logic             word_valid,
  input logic             frame_err,
  input logic [IDX_W-1:0] word_dev
);

  localparam int unsigned GAP_W = $clog2(WORD_W) + 2;

  logic [GAP_W-1:0] gap_q;
  logic [IDX_W-1:0] last_dev_q;

  // Counts clocks since the last word (saturating) and remembers its index.
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q      <= '1;
      last_dev_q <= '0;
    end else if (word_valid) begin
      gap_q      <= '0;
      last_dev_q <= word_dev;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!word_valid && !frame_err));

  assert_first_word_sync_low_R2: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_dev == '0) |-> !$past(fsync_in));

  assert_word_spacing_R3: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> (gap_q >= GAP_W'(WORD_W - 1)));

  assert_index_step_R4: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_dev != '0) |-> (word_dev == IDX_W'(last_dev_q + 1'b1)));

  assert_error_no_word_R6: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> !word_valid);

  assert_later_word_sync_high_R7: assert property (@(posedge clk) disable iff (rst)
    (word_valid && word_dev != '0) |-> $past(fsync_in));

endmodule

bind chain_word_rx cwr_checker #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .fsync_in   (fsync_in),
  .word_valid (word_valid),
  .frame_err  (frame_err),
  .word_dev   (word_dev)
);

// File: tb/sim_chain_word_rx.sv
`timescale 1ns/1ps
module sim_chain_word_rx;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sdo_in = 1'b0;
  logic        fsync_in = 1'b1;
  logic [3:0]  dev_count = 4'd1;
  logic [31:0] word_data;
  logic [2:0]  word_dev;
  logic        word_valid;
  logic        frame_err;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chain_word_rx u0 (
    .clk        (clk),
    .rst        (rst),
    .sdo_in     (sdo_in),
    .fsync_in   (fsync_in),
    .dev_count  (dev_count),
    .word_data  (word_data),
    .word_dev   (word_dev),
    .word_valid (word_valid),
    .frame_err  (frame_err)
  );

  // Frame vectors: {configured count, words sent, base pattern}.
  localparam logic [39:0] VEC [0:5] = '{
    {4'd1,  4'd1, 32'hA5C3_0F81},
    {4'd4,  4'd4, 32'h1234_5678},
    {4'd8,  4'd8, 32'hDEAD_BEEF},
    {4'd2,  4'd5, 32'h0000_0001},
    {4'd0,  4'd2, 32'h8000_0000},
    {4'd12, 4'd9, 32'hC001_D00D}
  };

  function automatic logic [31:0] word_of(input logic [31:0] base, input int k);
    return base ^ (32'h9E37_79B9 * 32'(k + 1));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one bit at the falling edge, then settle just after the rising edge.
  task automatic put_bit(input logic fs, input logic d);
    @(negedge clk);
    fsync_in = fs;
    sdo_in   = d;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    fsync_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_frame(input int cfg, input int nw, input logic [31:0] base);
    int eff;
    int stray;
    logic [31:0] w;
    eff = (cfg == 0) ? 1 : ((cfg > 8) ? 8 : cfg);
    stray = 0;
    dev_count = 4'(cfg);
    put_bit(1'b1, 1'b0);
    put_bit(1'b1, 1'b1);
    for (int k = 0; k < nw; k++) begin
      w = word_of(base, k);
      for (int b = 31; b >= 0; b--) begin
        put_bit(k != 0, w[b]);
        if (frame_err) stray++;
        if (b == 0 && k < eff) begin
          chk(word_valid == 1'b1, "R3 valid strobe", 64'(word_valid), 64'd1);
          chk(word_data == w, "R2 word content", 64'(word_data), 64'(w));
          chk(word_dev == 3'(k), "R4 chain index", 64'(word_dev), 64'(k));
        end else if (word_valid) begin
          stray++;
        end
      end
    end
    for (int i = 0; i < 3; i++) begin
      put_bit(1'b1, 1'(i));
      if (word_valid || frame_err) stray++;
    end
    chk(stray == 0, "R5 no extra words or errors", 64'(stray), 64'd0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
    end
  end

  initial begin
    int cnt;
    logic [31:0] nwd;
    logic [31:0] last_w;

    // R1: reset state, with frame sync low from reset onwards.
    fsync_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(word_valid == 1'b0, "R1 reset valid", 64'(word_valid), 64'd0);
    chk(frame_err == 1'b0, "R1 reset err", 64'(frame_err), 64'd0);
    chk(word_data == 32'd0, "R1 reset data", 64'(word_data), 64'd0);
    chk(word_dev == 3'd0, "R1 reset index", 64'(word_dev), 64'd0);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      put_bit(1'b0, 1'(i % 3));
      if (word_valid) cnt++;
    end
    chk(cnt == 0, "R1 low sync from reset opens no frame", 64'(cnt), 64'd0);

    // Table of frames: R2, R3, R4, R5.
    do_reset();
    for (int v = 0; v < 6; v++) begin
      run_frame(int'(VEC[v][39:36]), int'(VEC[v][35:32]), VEC[v][31:0]);
    end

    // R3: data and index hold after the last frame (last delivered word index 7).
    last_w = word_of(32'hC001_D00D, 7);
    for (int i = 0; i < 5; i++) put_bit(1'b1, 1'b1);
    chk(word_data == last_w, "R3 data held", 64'(word_data), 64'(last_w));
    chk(word_dev == 3'd7, "R3 index held", 64'(word_dev), 64'd7);

    // R6: frame sync released early in word 0.
    do_reset();
    dev_count = 4'd2;
    put_bit(1'b1, 1'b0);
    put_bit(1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      put_bit(1'b0, 1'b0);
      chk(frame_err == 1'b0, "R6 no error while sync low", 64'(frame_err), 64'd0);
    end
    put_bit(1'b1, 1'b1);
    chk(frame_err == 1'b1, "R6 early release error", 64'(frame_err), 64'd1);
    cnt = 0;
    for (int i = 0; i < 70; i++) begin
      put_bit(1'b1, 1'(i % 2));
      if (word_valid || frame_err) cnt++;
    end
    chk(cnt == 0, "R6 frame abandoned", 64'(cnt), 64'd0);

    // R7: new fall in the middle of word 1 restarts the frame.
    do_reset();
    dev_count = 4'd3;
    put_bit(1'b1, 1'b0);
    for (int b = 31; b >= 0; b--) put_bit(1'b0, b[0]);
    chk(word_valid == 1'b1 && word_dev == 3'd0, "R7 first word before restart", 64'({word_valid, word_dev}), 64'h8);
    for (int i = 0; i < 4; i++) put_bit(1'b1, 1'b0);
    nwd = 32'h5A96_3C0F;
    put_bit(1'b0, nwd[31]);
    chk(frame_err == 1'b1, "R7 fall mid-frame error", 64'(frame_err), 64'd1);
    for (int b = 30; b >= 0; b--) put_bit(1'b0, nwd[b]);
    chk(word_valid == 1'b1, "R7 restarted word valid", 64'(word_valid), 64'd1);
    chk(word_data == nwd, "R7 restarted word data", 64'(word_data), 64'(nwd));
    chk(word_dev == 3'd0, "R7 restarted word index", 64'(word_dev), 64'd0);

    // R7: sync stuck low into word 1 abandons the frame.
    do_reset();
    dev_count = 4'd2;
    put_bit(1'b1, 1'b0);
    for (int b = 31; b >= 0; b--) put_bit(1'b0, 1'b1);
    chk(word_data == 32'hFFFF_FFFF, "R2 all-ones word", 64'(word_data), 64'hFFFF_FFFF);
    put_bit(1'b0, 1'b0);
    chk(frame_err == 1'b1, "R7 stuck low error", 64'(frame_err), 64'd1);
    cnt = 0;
    for (int i = 0; i < 40; i++) begin
      put_bit(1'b1, 1'b1);
      if (word_valid) cnt++;
    end
    chk(cnt == 0, "R7 abandoned frame gives no word", 64'(cnt), 64'd0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule